// File: doc/BRIEF.md
# Byte-Wide SPI Shift Port

This block is a small memory-mapped SPI master. It has one 8-bit shifter and two 16-bit registers: a data register and a control/status register. Software drives each byte through a two-step handshake. It writes the byte to the data register. It then writes the control register with the strobe bit set and waits until the accepted flag reads back as one. Next it writes the control register again with the strobe cleared, and waits for the completion flag. Two device selects come straight from control bits. A direction bit chooses between shifting the data byte out and shifting a byte in from the serial input.

The serial clock idles low. Output data changes only while the clock is low, and input data is sampled on each rising clock edge. Each clock half-period lasts `CLK_DIV` system cycles, so a byte takes `16*CLK_DIV` cycles from acceptance to completion. The bus read path is combinational. The host's register writes take effect on the next rising edge of `clk`.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, the data register reads 0x0000, the control register reads 0x0000, both `cs_n` lines are high, and `sclk` and `mosi` are low.
- R2: Control bit 0 drives `cs_n[0]` low and control bit 1 drives `cs_n[1]` low. Writing 0x0000 to the control register raises both selects on the next cycle.
- R3: The data register (address 0) reads back the last value the host wrote. Control bits 0, 1, 2 and 4 (address 1) read back as written. Bits 3 and 5 are status, and host writes to them are ignored.
- R4: A control write with bit 4 set, made while no byte is in flight, is accepted. From the next cycle, bit 5 (LOADED) reads 1 and bit 3 (DONE) reads 0.
- R5: A control write with bit 4 clear makes LOADED read 0 from the next cycle.
- R6: With bit 2 = 0 (write), the low byte of the data register goes out on `mosi` MSB first, one bit per rising `sclk`, with exactly 8 pulses. The data register is left unchanged.
- R7: With bit 2 = 1 (read), `mosi` stays 0. `miso` is sampled on each of 8 rising `sclk` edges, MSB first. At completion the data register holds {8'h00, received byte}.
- R8: `sclk` is low whenever no byte is in flight. `mosi` never changes while `sclk` stays high. Each half-period is `CLK_DIV` cycles, and completion comes `16*CLK_DIV` cycles after the accepting edge.
- R9: DONE rises only when the byte has finished and the strobe bit is clear. If the strobe is still set at completion, DONE waits until it is cleared. LOADED and DONE are never both 1.
- R10: A strobe written while a byte is in flight, or while the finished byte awaits the strobe clear, has no effect. LOADED stays 0, no extra `sclk` pulses occur, and the byte in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 1 | Register select: 0 data, 1 control/status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low device selects |

## Verification
A stuck or mis-sequenced handshake state shows up at the next control read: LOADED or DONE takes a wrong value, or DONE never appears within `16*CLK_DIV` cycles. A wrong shifter or divider state shows up within one byte, as a wrong pulse count, a wrong bit order on `mosi`, or a wrong received byte in the data register. Each byte is therefore checked by bit content, by pulse count and by the exact cycle distance from acceptance to DONE. This exposes off-by-one errors in the bit and divider counters.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;
    localparam int NUM_CS = 2;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    // control/status bit positions (software decodes these)
    localparam int CB_CS0    = 0;
    localparam int CB_DIR    = 2;
    localparam int CB_DONE   = 3;
    localparam int CB_STROBE = 4;
    localparam int CB_LOADED = 5;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SHIFT = 2'd1,
        HS_HOLD  = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic [NUM_CS-1:0] cs;
        logic              dir;
        logic              strobe;
    } ctrl_fields_t;

    typedef struct packed {
        logic              rd;
        logic [BYTE_W-1:0] tx;
    } xfer_req_t;

    function automatic ctrl_fields_t decode_ctrl(input logic [REG_W-1:0] w);
        ctrl_fields_t c;
        c.cs     = w[CB_CS0 +: NUM_CS];
        c.dir    = w[CB_DIR];
        c.strobe = w[CB_STROBE];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input ctrl_fields_t c,
                                                     input logic done,
                                                     input logic loaded);
        logic [REG_W-1:0] r;
        r = '0;
        r[CB_CS0 +: NUM_CS] = c.cs;
        r[CB_DIR]           = c.dir;
        r[CB_DONE]          = done;
        r[CB_STROBE]        = c.strobe;
        r[CB_LOADED]        = loaded;
        return r;
    endfunction

endpackage

// File: rtl/spi_byte_regs.sv
module spi_byte_regs
    import spi_byte_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [REG_W-1:0]  data_q,
    output ctrl_fields_t      ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (we && addr == ADDR_DATA) begin
            data_q <= wdata;
        end else if (rx_valid) begin
            data_q <= {{(REG_W-BYTE_W){1'b0}}, rx_byte};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (we && addr == ADDR_CTRL) begin
            ctrl_q <= decode_ctrl(wdata);
        end
    end

endmodule

// File: rtl/spi_byte_hshake.sv
module spi_byte_hshake
    import spi_byte_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wr_strobe,
    input  logic strobe_q,
    input  logic fin,
    output logic start,
    output logic busy,
    output logic loaded,
    output logic done
);

    hs_state_e state;

    assign start = (state == HS_IDLE) && ctrl_wr && wr_strobe;
    assign busy  = (state != HS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= HS_IDLE;
            loaded <= 1'b0;
            done   <= 1'b0;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (start) begin
                        state  <= HS_SHIFT;
                        loaded <= 1'b1;
                        done   <= 1'b0;
                    end
                end
                HS_SHIFT: begin
                    if (fin) begin
                        if (strobe_q) begin
                            state <= HS_HOLD;
                        end else begin
                            state <= HS_IDLE;
                            done  <= 1'b1;
                        end
                    end
                end
                HS_HOLD: begin
                    if (!strobe_q) begin
                        state <= HS_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= HS_IDLE;
            endcase
            if (ctrl_wr && !wr_strobe) begin
                loaded <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
    import spi_byte_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         req,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              fin,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    logic              active;
    logic              sclk_q;
    logic              samp;
    logic              rd_q;
    logic [CNT_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              half_end;

    assign half_end = active && (div_cnt == DIV_LAST);
    assign fin      = half_end && sclk_q && (bit_cnt == BIT_LAST);
    assign rx_valid = fin && rd_q;
    assign rx_byte  = {shreg[BYTE_W-2:0], samp};
    assign sclk     = sclk_q;
    assign mosi     = active && shreg[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sclk_q  <= 1'b0;
            samp    <= 1'b0;
            rd_q    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (start) begin
            active  <= 1'b1;
            sclk_q  <= 1'b0;
            rd_q    <= req.rd;
            div_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= req.tx;
        end else if (half_end) begin
            div_cnt <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                samp   <= miso;
            end else begin
                sclk_q  <= 1'b0;
                shreg   <= {shreg[BYTE_W-2:0], samp};
                bit_cnt <= bit_cnt + 1'b1;
                if (fin) begin
                    active <= 1'b0;
                end
            end
        end else if (active) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_byte_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [1:0]  cs_n
);

    logic [REG_W-1:0]  data_q;
    ctrl_fields_t      ctrl_q;
    ctrl_fields_t      wr_fields;
    xfer_req_t         req;
    logic              ctrl_wr;
    logic              strobe_lvl;
    logic              hs_start;
    logic              hs_busy;
    logic              hs_loaded;
    logic              hs_done;
    logic              sh_fin;
    logic              sh_rx_valid;
    logic [BYTE_W-1:0] sh_rx_byte;

    assign ctrl_wr    = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_fields  = decode_ctrl(bus_wdata);
    assign strobe_lvl = ctrl_q.strobe;
    assign req.rd     = wr_fields.dir;
    assign req.tx     = wr_fields.dir ? '0 : data_q[BYTE_W-1:0];

    spi_byte_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rx_valid (sh_rx_valid),
        .rx_byte  (sh_rx_byte),
        .data_q   (data_q),
        .ctrl_q   (ctrl_q)
    );

    spi_byte_hshake i_hshake (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .wr_strobe (wr_fields.strobe),
        .strobe_q  (strobe_lvl),
        .fin       (sh_fin),
        .start     (hs_start),
        .busy      (hs_busy),
        .loaded    (hs_loaded),
        .done      (hs_done)
    );

    spi_byte_shifter #(.CLK_DIV(CLK_DIV)) i_shifter (
        .clk      (clk),
        .rst      (rst),
        .start    (hs_start),
        .req      (req),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .fin      (sh_fin),
        .rx_valid (sh_rx_valid),
        .rx_byte  (sh_rx_byte)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = ~ctrl_q.cs[g];
    end

    assign bus_rdata = (bus_addr == ADDR_DATA) ? data_q
                                               : pack_status(ctrl_q, hs_done, hs_loaded);

endmodule

// File: rtl/spi_byte_port_chk.sv
module spi_byte_port_chk
    import spi_byte_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              sclk,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n,
    input logic              busy,
    input logic              loaded,
    input logic              done,
    input logic              strobe
);

    logic ctrl_wr;
    assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);

    p_cs_release_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata == '0) |=> (cs_n == '1));

    p_accept_loaded_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && ctrl_wr && bus_wdata[CB_STROBE]) |=> (loaded && !done));

    p_loaded_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[CB_STROBE]) |=> !loaded);

    p_mosi_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_sclk_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

    p_done_gate_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !strobe);

    p_flag_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(loaded && done));

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !loaded && ctrl_wr && bus_wdata[CB_STROBE]) |=> !loaded);

endmodule

bind spi_byte_port spi_byte_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .busy      (hs_busy),
    .loaded    (hs_loaded),
    .done      (hs_done),
    .strobe    (strobe_lvl)
);

// File: tb/test_spi_byte_port.sv
module test_spi_byte_port;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int NV         = 6;

    // entry: {read, data word, miso pattern}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 16'hBEA5, 8'h00},
        {1'b1, 16'h7777, 8'h96},
        {1'b0, 16'h123C, 8'hFF},
        {1'b1, 16'h0000, 8'hFF},
        {1'b0, 16'hC001, 8'hAA},
        {1'b1, 16'hFFFF, 8'h01}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic [1:0]  cs_n;

    int          checks = 0;
    int          fails = 0;
    int          cyc = 0;
    int          rises = 0;
    int          midx = -1;
    logic [7:0]  cap = '0;
    logic [7:0]  mpat = '0;

    spi_byte_port #(.CLK_DIV(DIV)) i_spi_byte_port (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sclk) begin
        cap   = {cap[6:0], mosi};
        rises = rises + 1;
    end

    always @(negedge sclk) begin
        if (midx >= 0) begin
            miso = mpat[midx];
            midx = midx - 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_done(output int elapsed, input int t0);
        logic [15:0] r;
        elapsed = -1;
        for (int n = 0; n < 2000; n++) begin
            bus_rd(1'b1, r);
            if (r[3]) begin
                elapsed = cyc - t0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_xfer(input logic rd, input logic [15:0] w, input logic [7:0] mi,
                            input logic [1:0] cs);
        logic [15:0] r;
        logic [15:0] ctl;
        int t0;
        int el;
        bus_wr(1'b0, w);
        mpat = mi; miso = mi[7]; midx = 6; rises = 0; cap = '0;
        ctl = {11'd0, 1'b1, 1'b0, rd, cs};
        bus_wr(1'b1, ctl);
        t0 = cyc;
        bus_rd(1'b1, r);
        chk("R4 loaded after strobe", r[5], 1'b1);
        chk("R4 done cleared by strobe", r[3], 1'b0);
        bus_wr(1'b1, ctl & 16'hFFEF);
        bus_rd(1'b1, r);
        chk("R5 loaded cleared", r[5], 1'b0);
        wait_done(el, t0);
        chk("R8 cycles to done", el, 16 * DIV);
        chk("R8 pulse count", rises, 8);
        chk("R8 sclk idle low", sclk, 1'b0);
        bus_rd(1'b0, r);
        if (!rd) begin
            chk("R6 mosi byte", cap, w[7:0]);
            chk("R6 data kept", r, w);
        end else begin
            chk("R7 mosi zero", cap, 8'h00);
            chk("R7 received data", r, {8'h00, mi});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] r;
        int el;
        int t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_rd(1'b0, r); chk("R1 data reset", r, 16'h0000);
        bus_rd(1'b1, r); chk("R1 ctrl reset", r, 16'h0000);
        chk("R1 cs_n reset", cs_n, 2'b11);
        chk("R1 sclk reset", sclk, 1'b0);
        chk("R1 mosi reset", mosi, 1'b0);

        // R2 selects
        bus_wr(1'b1, 16'h0001); chk("R2 cs0", cs_n, 2'b10);
        bus_wr(1'b1, 16'h0002); chk("R2 cs1", cs_n, 2'b01);
        bus_wr(1'b1, 16'h0003); chk("R2 both", cs_n, 2'b00);
        bus_wr(1'b1, 16'h0000); chk("R2 release", cs_n, 2'b11);

        // R3 readback, status bits not writable
        bus_wr(1'b0, 16'h1234); bus_rd(1'b0, r); chk("R3 data readback", r, 16'h1234);
        bus_wr(1'b1, 16'h002F); bus_rd(1'b1, r); chk("R3 ctrl readback", r, 16'h0007);
        chk("R3 no transfer from status write", sclk, 1'b0);
        bus_wr(1'b1, 16'h0000);

        // table walk: R4..R8
        for (int i = 0; i < NV; i++) begin
            run_xfer(VEC[i][24], VEC[i][23:8], VEC[i][7:0], VEC[i][24] ? 2'b10 : 2'b01);
        end

        // R10 / R9: strobe during shift, completion with strobe still set
        bus_wr(1'b0, 16'h005A);
        mpat = 8'h00; miso = 1'b0; midx = 6; rises = 0; cap = '0;
        bus_wr(1'b1, 16'h0011);
        t0 = cyc;
        bus_wr(1'b1, 16'h0001);
        repeat (4 * DIV) @(negedge clk);
        bus_wr(1'b1, 16'h0011);
        bus_rd(1'b1, r);
        chk("R10 loaded stays low mid-shift", r[5], 1'b0);
        repeat (20 * DIV) @(negedge clk);
        bus_rd(1'b1, r);
        chk("R9 done held while strobe set", r[3], 1'b0);
        chk("R10 loaded still low", r[5], 1'b0);
        chk("R10 no extra pulses", rises, 8);
        chk("R10 byte undisturbed", cap, 8'h5A);
        bus_wr(1'b1, 16'h0011);
        repeat (4 * DIV) @(negedge clk);
        chk("R10 no pulses while awaiting clear", rises, 8);
        bus_wr(1'b1, 16'h0001);
        @(negedge clk);
        bus_rd(1'b1, r);
        chk("R9 done after strobe clear", r[3], 1'b1);
        chk("R9 loaded low with done", r[5], 1'b0);

        // R9 done clears on new accepted strobe
        mpat = 8'h3C; miso = 1'b0; midx = 6; rises = 0;
        bus_wr(1'b1, 16'h0015);
        t0 = cyc;
        bus_rd(1'b1, r);
        chk("R9 done cleared by new strobe", r[3], 1'b0);
        bus_wr(1'b1, 16'h0005);
        wait_done(el, t0);
        chk("R8 cycles to done (second)", el, 16 * DIV);
        bus_rd(1'b0, r);
        chk("R7 received after restart", r, 16'h003C);
        bus_wr(1'b1, 16'h0000);
        chk("R2 release at end", cs_n, 2'b11);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule